// File: doc/BRIEF.md
# Multi-Lane Symbol Serializer with Alignment FIFO

This block is the last parallel-to-serial stage of a transmit lane. A producer writes parallel words, each holding one, two or four 10-bit line symbols. The symbols either arrive already encoded or are assembled from a data byte plus two side bits when the encoder is bypassed. Words first pass through a four-entry alignment FIFO. The serializer then drains them one bit per clock, so the block clock is the bit clock.

The serializer emits the symbols of a word from the lowest lane upwards, and each symbol least significant bit first. Consecutive words follow with no gap. When a symbol boundary arrives and no word is waiting, a fixed idle code group is sent. Writing into a full FIFO drops the word. Both error conditions latch into sticky flags, which a clear input resets. An invert control flips every outgoing bit, so that a board with a swapped differential pair can be corrected.

Top module: `symbol_serializer`

## Requirements
- R1: The lane count of a word is taken from `wr_mode` at the write: 2'b00 gives 1 symbol, 2'b01 gives 2 symbols, and 2'b10 or 2'b11 give 4 symbols. In encoded mode, symbol i is `wr_code[10*i+9:10*i]`, and lanes above the count are ignored.
- R2: Symbols of a word leave in lane order 0, 1, 2, 3, each starting with its bit 0. Words and idle groups follow each other with no gap. The first bit after reset starts a symbol, so the output stream is aligned to 10-bit symbols counted from the first clock after reset.
- R3: When `wr_bypass` is 1, symbol i is sent in this order: `wr_ctl_a[i]`, then `wr_ctl_b[i]`, then `wr_byte[8*i+7:8*i]` from bit 0 to bit 7. That is, the symbol value is {byte, ctl_b, ctl_a}.
- R4: The FIFO holds four words. A write while it is full and no word leaves in the same cycle is discarded and raises `ovf_err`. A write into a full FIFO in the cycle a word leaves is accepted.
- R5: At a symbol boundary with an empty FIFO, the idle code 10'h17C is sent, bit 0 first. If at least one word has been sent since the last idle, this sets `unf_err`. Idle groups before the first word, or repeated idle groups after a dry-out, do not set it again.
- R6: `ovf_err` and `unf_err` stay set until `err_clr` is seen at a clock edge. They read 0 from the next edge on. An error event in the same cycle as the clear leaves the flag set.
- R7: When `tx_invert` is 1, every outgoing bit, idle groups included, is the complement of the bit that would be sent with `tx_invert` at 0.
- R8: While `rst_n` is low, `tx_o`, `ovf_err` and `unf_err` are 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write a word into the FIFO this cycle |
| wr_mode | input | 2 | Lane count select for the word |
| wr_bypass | input | 1 | Build symbols from byte and side bits |
| wr_code | input | 40 | Four pre-encoded 10-bit symbols, lane 0 lowest |
| wr_byte | input | 32 | Four data bytes for bypass mode, lane 0 lowest |
| wr_ctl_a | input | 4 | First side bit for each lane in bypass mode |
| wr_ctl_b | input | 4 | Second side bit for each lane in bypass mode |
| tx_invert | input | 1 | Invert output polarity |
| err_clr | input | 1 | Clear both sticky error flags |
| tx_o | output | 1 | Serial output bit |
| ovf_err | output | 1 | Sticky FIFO overflow flag |
| unf_err | output | 1 | Sticky FIFO underflow flag |

## Verification
Two pairs of events can land in the same cycle. The first is a write into a full FIFO on the edge where the serializer pulls a word. The bench fills the FIFO while the first idle group is still leaving and places a fifth write exactly on the first word boundary. It then expects a clean overflow flag and all five words in the stream. The second is a clear that coincides with an overflow: the clear is driven together with the overflowing write, and the flag must still read 1 afterwards.

// File: rtl/sersym_pkg.sv
package sersym_pkg;

    localparam int SYM_BITS  = 10;
    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        LANE_ONE  = 2'b00,
        LANE_TWO  = 2'b01,
        LANE_FOUR = 2'b10,
        LANE_WIDE = 2'b11
    } lane_mode_e;

    // number of symbols carried by a word for a given mode
    function automatic logic [2:0] lane_count(input lane_mode_e mode);
        case (mode)
            LANE_ONE: return 3'd1;
            LANE_TWO: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/word_pack.sv
module word_pack #(
    parameter int LANES  = 4,
    parameter int SYM_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [LANES*SYM_W-1:0]  code,
    input  logic [LANES*BYTE_W-1:0] bytes,
    input  logic [LANES-1:0]        ctl_a,
    input  logic [LANES-1:0]        ctl_b,
    input  logic                    bypass,
    output logic [LANES*SYM_W-1:0]  word
);

    // bypass symbol: side bit a leaves first, then side bit b, then the byte
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign word[i*SYM_W +: SYM_W] = bypass
            ? {bytes[i*BYTE_W +: BYTE_W], ctl_b[i], ctl_a[i]}
            : code[i*SYM_W +: SYM_W];
    end

endmodule

// File: rtl/align_fifo.sv
module align_fifo #(
    parameter int WIDTH = 43,
    parameter int DEPTH = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [WIDTH-1:0]                   wr_data,
    input  logic                               rd_en,
    output logic [WIDTH-1:0]                   rd_data,
    output logic                               empty,
    output logic [$clog2(DEPTH+1)-1:0]         level,
    output logic                               ovf_evt
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wp;
        logic [PTR_W-1:0]            rp;
        logic [LVL_W-1:0]            lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     full, do_rd, do_wr;

    assign empty   = (st_q.lvl == '0);
    assign full    = (st_q.lvl == LVL_W'(DEPTH));
    assign level   = st_q.lvl;
    assign rd_data = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_rd   = rd_en && !empty;
        do_wr   = wr_en && (!full || do_rd);
        ovf_evt = wr_en && full && !do_rd;
        if (do_wr) begin
            st_d.mem[st_q.wp] = wr_data;
            st_d.wp = (st_q.wp == PTR_W'(DEPTH-1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_rd) begin
            st_d.rp = (st_q.rp == PTR_W'(DEPTH-1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
    parameter int               LANES     = 4,
    parameter int               SYM_W     = 10,
    parameter logic [SYM_W-1:0] IDLE_CODE = 10'h17C
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES*SYM_W-1:0]       word,
    input  logic [$clog2(LANES+1)-1:0]   lanes,
    input  logic                         avail,
    input  logic                         invert,
    output logic                         pop,
    output logic                         unf_evt,
    output logic                         tx
);

    localparam int WORD_W = LANES * SYM_W;
    localparam int REM_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sreg;
        logic [REM_W-1:0]  rem;
        logic              armed;
        logic              tx;
    } shf_st_t;

    shf_st_t st_d, st_q;
    logic    out_bit;

    assign tx = st_q.tx;

    always_comb begin
        st_d    = st_q;
        pop     = 1'b0;
        unf_evt = 1'b0;
        if (st_q.rem == '0) begin
            if (avail) begin
                pop        = 1'b1;
                out_bit    = word[0];
                st_d.sreg  = word >> 1;
                st_d.rem   = REM_W'(int'(lanes) * SYM_W - 1);
                st_d.armed = 1'b1;
            end else begin
                out_bit   = IDLE_CODE[0];
                st_d.sreg = WORD_W'(IDLE_CODE) >> 1;
                st_d.rem  = REM_W'(SYM_W - 1);
                if (st_q.armed) begin
                    unf_evt    = 1'b1;
                    st_d.armed = 1'b0;
                end
            end
        end else begin
            out_bit   = st_q.sreg[0];
            st_d.sreg = st_q.sreg >> 1;
            st_d.rem  = st_q.rem - 1'b1;
        end
        st_d.tx = out_bit ^ invert;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/symbol_serializer.sv
module symbol_serializer
    import sersym_pkg::*;
#(
    parameter int               LANES      = 4,
    parameter int               SYM_W      = SYM_BITS,
    parameter int               BYTE_W     = BYTE_BITS,
    parameter int               FIFO_DEPTH = 4,
    parameter logic [SYM_W-1:0] IDLE_CODE  = SYM_W'(10'h17C)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [1:0]              wr_mode,
    input  logic                    wr_bypass,
    input  logic [LANES*SYM_W-1:0]  wr_code,
    input  logic [LANES*BYTE_W-1:0] wr_byte,
    input  logic [LANES-1:0]        wr_ctl_a,
    input  logic [LANES-1:0]        wr_ctl_b,
    input  logic                    tx_invert,
    input  logic                    err_clr,
    output logic                    tx_o,
    output logic                    ovf_err,
    output logic                    unf_err
);

    localparam int WORD_W  = LANES * SYM_W;
    localparam int LC_W    = $clog2(LANES + 1);
    localparam int ENTRY_W = WORD_W + LC_W;
    localparam int LVL_W   = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic ovf;
        logic unf;
    } flag_st_t;

    flag_st_t          flg_d, flg_q;
    logic [WORD_W-1:0] packed_word;
    logic [LC_W-1:0]   wr_lanes;
    logic [ENTRY_W-1:0] rd_entry;
    logic              fifo_empty;
    logic [LVL_W-1:0]  fifo_level;
    logic              pop;
    logic              ovf_evt;
    logic              unf_evt;

    assign wr_lanes = LC_W'(lane_count(lane_mode_e'(wr_mode)));

    word_pack #(
        .LANES  (LANES),
        .SYM_W  (SYM_W),
        .BYTE_W (BYTE_W)
    ) u_pack (
        .code   (wr_code),
        .bytes  (wr_byte),
        .ctl_a  (wr_ctl_a),
        .ctl_b  (wr_ctl_b),
        .bypass (wr_bypass),
        .word   (packed_word)
    );

    align_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_valid),
        .wr_data ({wr_lanes, packed_word}),
        .rd_en   (pop),
        .rd_data (rd_entry),
        .empty   (fifo_empty),
        .level   (fifo_level),
        .ovf_evt (ovf_evt)
    );

    bit_shifter #(
        .LANES     (LANES),
        .SYM_W     (SYM_W),
        .IDLE_CODE (IDLE_CODE)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .word    (rd_entry[WORD_W-1:0]),
        .lanes   (rd_entry[ENTRY_W-1:WORD_W]),
        .avail   (!fifo_empty),
        .invert  (tx_invert),
        .pop     (pop),
        .unf_evt (unf_evt),
        .tx      (tx_o)
    );

    // sticky flags: a new event outranks a clear in the same cycle
    always_comb begin
        flg_d.ovf = (flg_q.ovf & ~err_clr) | ovf_evt;
        flg_d.unf = (flg_q.unf & ~err_clr) | unf_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign ovf_err = flg_q.ovf;
    assign unf_err = flg_q.unf;

endmodule

// File: rtl/serializer_checker.sv
module serializer_checker #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_valid,
    input logic                       err_clr,
    input logic                       ovf_err,
    input logic                       unf_err,
    input logic                       pop,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       ovf_evt,
    input logic                       unf_evt
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R4

    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && level == LVL_W'(DEPTH) && !pop) |=> ovf_err); // R4

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> level != '0); // R2

    AST_UNF_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |-> (level == '0 && !pop)); // R5

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !err_clr) |=> ovf_err); // R6

    AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_err && !err_clr) |=> unf_err); // R6

    AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !ovf_evt) |=> !ovf_err); // R6

    AST_UNF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !unf_evt) |=> !unf_err); // R6

endmodule

bind symbol_serializer serializer_checker #(.DEPTH(FIFO_DEPTH)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .err_clr  (err_clr),
    .ovf_err  (ovf_err),
    .unf_err  (unf_err),
    .pop      (pop),
    .level    (fifo_level),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt)
);

// File: tb/tb_symbol_serializer.sv
module tb_symbol_serializer;

    localparam int         CLK_PERIOD = 10;
    localparam logic [9:0] IDLE       = 10'h17C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid, wr_bypass, tx_invert, err_clr;
    logic [1:0]  wr_mode;
    logic [39:0] wr_code;
    logic [31:0] wr_byte;
    logic [3:0]  wr_ctl_a, wr_ctl_b;
    logic        tx_o, ovf_err, unf_err;

    int total = 0;
    int bad   = 0;
    bit cap_en = 1'b0;
    bit done   = 1'b0;
    bit bitq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    symbol_serializer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_mode   (wr_mode),
        .wr_bypass (wr_bypass),
        .wr_code   (wr_code),
        .wr_byte   (wr_byte),
        .wr_ctl_a  (wr_ctl_a),
        .wr_ctl_b  (wr_ctl_b),
        .tx_invert (tx_invert),
        .err_clr   (err_clr),
        .tx_o      (tx_o),
        .ovf_err   (ovf_err),
        .unf_err   (unf_err)
    );

    // capture one output bit per clock, just after the edge
    always @(posedge clk) begin
        #1;
        if (cap_en) bitq.push_back(tx_o);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        wr_valid  = 1'b0;
        wr_mode   = 2'b00;
        wr_bypass = 1'b0;
        wr_code   = '0;
        wr_byte   = '0;
        wr_ctl_a  = '0;
        wr_ctl_b  = '0;
        err_clr   = 1'b0;
    endtask

    task automatic start(input bit inv);
        cap_en = 1'b0;
        rst_n  = 1'b0;
        quiet_inputs();
        tx_invert = inv;
        repeat (2) @(negedge clk);
        bitq.delete();
        rst_n  = 1'b1;
        cap_en = 1'b1;
    endtask

    task automatic put(input logic [1:0] mode, input bit byp, input logic [39:0] code,
                       input logic [31:0] bytes, input logic [3:0] ca, input logic [3:0] cb);
        wr_valid  = 1'b1;
        wr_mode   = mode;
        wr_bypass = byp;
        wr_code   = code;
        wr_byte   = bytes;
        wr_ctl_a  = ca;
        wr_ctl_b  = cb;
        @(negedge clk);
        wr_valid  = 1'b0;
    endtask

    function automatic logic [9:0] sym_at(input int j, input bit inv);
        logic [9:0] s;
        for (int k = 0; k < 10; k++) s[k] = bitq[10*j + k] ^ inv;
        return s;
    endfunction

    task automatic check_stream(input logic [9:0] exp[$], input bit inv, input string req,
                                input bit tail_idle, output int first);
        int n = bitq.size() / 10;
        int j = 0;
        while (j < n && sym_at(j, inv) == IDLE) j++;
        first = j;
        foreach (exp[e]) begin
            if (j + e >= n) chk(1'b0, req, "symbol missing", j + e, n);
            else chk(sym_at(j + e, inv) == exp[e], req, $sformatf("symbol %0d", e),
                     int'(sym_at(j + e, inv)), int'(exp[e]));
        end
        if (tail_idle) begin
            if (j + exp.size() >= n) chk(1'b0, req, "tail missing", j + exp.size(), n);
            else chk(sym_at(j + exp.size(), inv) == IDLE, req, "idle after data",
                     int'(sym_at(j + exp.size(), inv)), int'(IDLE));
        end
    endtask

    task automatic t_reset();
        int n;
        bit all_idle = 1'b1;
        rst_n = 1'b0;
        quiet_inputs();
        tx_invert = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_o == 1'b0, "R8", "tx in reset", tx_o, 0);
        chk(ovf_err == 1'b0, "R8", "ovf in reset", ovf_err, 0);
        chk(unf_err == 1'b0, "R8", "unf in reset", unf_err, 0);
        start(1'b0);
        repeat (40) @(negedge clk);
        n = bitq.size() / 10;
        for (int j = 0; j < n; j++) if (sym_at(j, 1'b0) != IDLE) all_idle = 1'b0;
        chk(all_idle && n >= 3, "R5", "idle before first word", n, 3);
        chk(unf_err == 1'b0, "R5", "no underflow before first word", unf_err, 0);
    endtask

    task automatic t_one_lane();
        int first;
        start(1'b0);
        put(2'b00, 1'b0, {30'h3FFFFFFF, 10'h123}, '0, '0, '0);
        put(2'b00, 1'b0, {30'h15555555, 10'h2F0}, '0, '0, '0);
        put(2'b00, 1'b0, {30'h0ABCDEF0, 10'h0CF}, '0, '0, '0);
        repeat (60) @(negedge clk);
        check_stream('{10'h123, 10'h2F0, 10'h0CF}, 1'b0, "R1", 1'b1, first);
        chk(first == 1, "R2", "first word at symbol 1", first, 1);
        chk(unf_err == 1'b1, "R5", "underflow after dry-out", unf_err, 1);
        chk(ovf_err == 1'b0, "R4", "no overflow", ovf_err, 0);
    endtask

    task automatic t_mixed_lanes();
        int first;
        start(1'b0);
        put(2'b01, 1'b0, {10'h3FF, 10'h3FF, 10'h222, 10'h111}, '0, '0, '0);
        put(2'b11, 1'b0, {10'h0F0, 10'h303, 10'h202, 10'h101}, '0, '0, '0);
        repeat (80) @(negedge clk);
        check_stream('{10'h111, 10'h222, 10'h101, 10'h202, 10'h303, 10'h0F0},
                     1'b0, "R2", 1'b1, first);
        chk(first == 1, "R1", "lane words back to back", first, 1);
    endtask

    task automatic t_bypass();
        int first;
        start(1'b0);
        put(2'b01, 1'b1, {10'h17C, 10'h17C, 10'h17C, 10'h17C},
            {8'h00, 8'h00, 8'h3C, 8'hA5}, 4'b0001, 4'b0010);
        repeat (50) @(negedge clk);
        check_stream('{10'h295, 10'h0F2}, 1'b0, "R3", 1'b1, first);
    endtask

    task automatic t_overflow();
        int first;
        start(1'b0);
        for (int w = 0; w < 5; w++) begin
            err_clr = (w == 4);
            put(2'b10, 1'b0, {10'(12'h40 + w*4 + 3), 10'(12'h40 + w*4 + 2),
                              10'(12'h40 + w*4 + 1), 10'(12'h40 + w*4)}, '0, '0, '0);
            err_clr = 1'b0;
        end
        chk(ovf_err == 1'b1, "R6", "event beats clear", ovf_err, 1);
        repeat (250) @(negedge clk);
        check_stream('{10'h40, 10'h41, 10'h42, 10'h43, 10'h44, 10'h45, 10'h46, 10'h47,
                       10'h48, 10'h49, 10'h4A, 10'h4B, 10'h4C, 10'h4D, 10'h4E, 10'h4F},
                     1'b0, "R4", 1'b1, first);
        chk(ovf_err == 1'b1, "R4", "overflow held", ovf_err, 1);
    endtask

    task automatic t_clear();
        chk(unf_err == 1'b1, "R6", "underflow set before clear", unf_err, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(ovf_err == 1'b0, "R6", "ovf cleared", ovf_err, 0);
        chk(unf_err == 1'b0, "R6", "unf cleared", unf_err, 0);
        repeat (40) @(negedge clk);
        chk(unf_err == 1'b0, "R5", "no refire on repeated idle", unf_err, 0);
        chk(ovf_err == 1'b0, "R6", "ovf stays clear", ovf_err, 0);
    endtask

    task automatic t_full_with_pop();
        int first;
        start(1'b0);
        for (int w = 0; w < 4; w++) put(2'b00, 1'b0, {30'h0, 10'(12'h0A0 + w)}, '0, '0, '0);
        repeat (6) @(negedge clk);
        put(2'b00, 1'b0, {30'h0, 10'h0B5}, '0, '0, '0);
        repeat (70) @(negedge clk);
        chk(ovf_err == 1'b0, "R4", "write at pop edge accepted", ovf_err, 0);
        check_stream('{10'h0A0, 10'h0A1, 10'h0A2, 10'h0A3, 10'h0B5}, 1'b0, "R4", 1'b1, first);
        chk(first == 1, "R2", "start after one idle", first, 1);
    endtask

    task automatic t_polarity();
        int first;
        start(1'b1);
        put(2'b00, 1'b0, {30'h0, 10'h0F3}, '0, '0, '0);
        put(2'b00, 1'b0, {30'h0, 10'h2C1}, '0, '0, '0);
        repeat (40) @(negedge clk);
        chk(bitq.size() > 0 && bitq[0] == 1'b1, "R7", "inverted idle bit 0",
            bitq.size() > 0 ? int'(bitq[0]) : -1, 1);
        chk(sym_at(0, 1'b0) == ~IDLE, "R7", "raw idle group", int'(sym_at(0, 1'b0)), int'(~IDLE));
        check_stream('{10'h0F3, 10'h2C1}, 1'b1, "R7", 1'b1, first);
    endtask

    initial begin
        quiet_inputs();
        tx_invert = 1'b0;
        t_reset();
        t_one_lane();
        t_mixed_lanes();
        t_bypass();
        t_overflow();
        t_clear();
        t_full_with_pop();
        t_polarity();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule